// File: doc/BRIEF.md
# Masked Interrupt Request Collector

This block gathers interrupt requests from several peripheral sources into one active-low request line for the processor. The sources include a timer compare match, a serial receiver that holds a received character, and a serial transmitter that can take a new character. Each request appears as one bit of a status word. A second word, the enable mask, decides which of those bits may reach the processor. The line goes low whenever at least one status bit is set and its mask bit is also set.

Sources come in two kinds, chosen per bit by a parameter. A pulse-type source, such as the timer match, sets its status bit on a rising edge, and the bit stays set until software writes a 1 to it. A level-type source, such as a ready flag, appears in the status word as its live value, and software cannot clear it through the status word. Both words sit on a simple synchronous register bus with a select, a write strobe, an address and data. Reads return data combinationally from the address.

Top module: `irq_gather`

## Requirements
- R1: After reset the enable mask is all zeros, every pulse-type status bit is 0, and `irq_n` is 1.
- R2: A rising edge on a pulse-type source (bit 0, the timer match, by default) sets its status bit at the next clock edge. The bit stays set after the source falls. A source held high does not set the bit again.
- R3: A bus write at address 0x18 clears each pulse-type status bit whose write-data bit is 1. Write-data bits that are 0 leave their status bits unchanged.
- R4: When a rising edge on a pulse-type source and a clearing write to the same bit fall in the same cycle, the bit ends up set.
- R5: Level-type bits (bit 6, transmitter ready, and bit 7, receiver ready, by default) read back in the status word as the live source value. Writes to the status word do not change them.
- R6: The enable mask at address 0x1C can be written and read back. Only the low NSRC bits are stored, and the upper data bits read as 0.
- R7: `irq_n` is 0 exactly when some bit is set in both the status word and the enable mask, and is 1 otherwise.
- R8: A masked request still shows as 1 in the status word.
- R9: A read from any address other than 0x18 or 0x1C returns 0, and a write to such an address changes neither word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src | input | NSRC | Interrupt source inputs, one per status bit |
| sel | input | 1 | Register bus select |
| wr | input | 1 | Write strobe, qualified by sel |
| addr | input | AW | Register byte address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for the addressed word, 0 if not selected or unmapped |
| irq_n | output | 1 | Active-low interrupt request to the processor |

## Verification
The bench targets the cycle where a timer edge and a clearing write to the same bit coincide. A design that gives the clear priority would lose that event and report the bit as 0. It checks that writes of 0 bits, writes of 1 to level-type bits, and writes to an unmapped address leave both words untouched. A design that writes the status word directly, or decodes too few address bits, would change them. It also holds a pulse-type source high across a clear to catch a design that treats it as a level. It then verifies that the request line stays high while a status bit is set but masked, and drops once the mask admits that bit.

// File: rtl/irq_gather.sv
module irq_gather #(
  parameter int NSRC = 8,
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] STAT_OFS = 8'h18,
  parameter logic [AW-1:0] EN_OFS = 8'h1C,
  parameter logic [NSRC-1:0] LEVEL_MAP = 8'hC0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic            sel,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            irq_n
);

  localparam logic [NSRC-1:0] EDGE_MAP = ~LEVEL_MAP;

  logic [NSRC-1:0] src_q, lat_q, en_q;
  logic [NSRC-1:0] clr, evt, stat, rd_word;

  wire hit_stat = sel & (addr == STAT_OFS);
  wire hit_en   = sel & (addr == EN_OFS);

  assign clr  = (hit_stat & wr) ? wdata[NSRC-1:0] : '0;
  assign evt  = src & ~src_q & EDGE_MAP;
  assign stat = (lat_q & EDGE_MAP) | (src & LEVEL_MAP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      lat_q <= '0;
      en_q  <= '0;
    end else begin
      src_q <= src;
      lat_q <= ((lat_q & ~clr) | evt) & EDGE_MAP;
      if (hit_en & wr) en_q <= wdata[NSRC-1:0];
    end
  end

  always_comb begin
    rd_word = '0;
    if (hit_stat)    rd_word = stat;
    else if (hit_en) rd_word = en_q;
  end

  assign rdata = DW'(rd_word);
  assign irq_n = ~|(stat & en_q);

endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk #(
  parameter int NSRC = 8,
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] STAT_OFS = 8'h18,
  parameter logic [AW-1:0] EN_OFS = 8'h1C,
  parameter logic [NSRC-1:0] LEVEL_MAP = 8'hC0
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src,
  input logic            sel,
  input logic            wr,
  input logic [AW-1:0]   addr,
  input logic [DW-1:0]   wdata,
  input logic [DW-1:0]   rdata,
  input logic            irq_n,
  input logic [NSRC-1:0] src_q,
  input logic [NSRC-1:0] lat_q,
  input logic [NSRC-1:0] en_q
);

  logic [NSRC-1:0] ones_written;
  assign ones_written = (sel && wr && addr == STAT_OFS) ? wdata[NSRC-1:0] : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    if (LEVEL_MAP[i]) begin : g_lvl
      p_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && addr == STAT_OFS) |-> (rdata[i] == src[i]));
    end else begin : g_edge
      p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src[i] && !src_q[i]) |=> lat_q[i]);
      p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q[i] && !ones_written[i]) |=> lat_q[i]);
      p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q[i] && ones_written[i] && !(src[i] && !src_q[i])) |=> !lat_q[i]);
      p_collide_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ones_written[i] && src[i] && !src_q[i]) |=> lat_q[i]);
    end
  end

  p_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == EN_OFS) |=> (en_q == $past(wdata[NSRC-1:0])));

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> irq_n);

  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && addr != STAT_OFS && addr != EN_OFS) |-> (rdata == '0));

endmodule

bind irq_gather irq_gather_chk #(
  .NSRC(NSRC), .AW(AW), .DW(DW), .STAT_OFS(STAT_OFS), .EN_OFS(EN_OFS), .LEVEL_MAP(LEVEL_MAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src(src), .sel(sel), .wr(wr), .addr(addr),
  .wdata(wdata), .rdata(rdata), .irq_n(irq_n),
  .src_q(src_q), .lat_q(lat_q), .en_q(en_q)
);

// File: tb/sim_irq_gather.sv
module sim_irq_gather;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  src = '0;
  logic        sel = 0;
  logic        wr = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_n;

  int checks = 0;
  int fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [7:0] A_ST = 8'h18;
  localparam logic [7:0] A_EN = 8'h1C;

  always #4 clk = ~clk;

  irq_gather u0 (
    .clk(clk), .rst_n(rst_n), .src(src), .sel(sel), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); sel = 0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    check(tag, {31'b0, irq_n}, {31'b0, exp});
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #2;
      if (sel && !wr && exp_q.size() > 0) check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  initial begin : watchdog
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    bus_rd(A_ST, 32'h0, "R1 status after reset");
    bus_rd(A_EN, 32'h0, "R1 enable after reset");
    chk_irq(1'b1, "R1 irq_n after reset");

    bus_wr(A_EN, 32'hFFFF_FFFF);
    bus_rd(A_EN, 32'h0000_00FF, "R6 enable readback upper zero");
    bus_wr(A_EN, 32'h0000_0000);
    bus_rd(A_EN, 32'h0, "R6 enable cleared");

    @(negedge clk); src[0] = 1;
    @(negedge clk); src[0] = 0;
    bus_rd(A_ST, 32'h01, "R2 timer edge latched");
    bus_rd(A_ST, 32'h01, "R8 masked bit visible");
    chk_irq(1'b1, "R8 masked request keeps irq_n high");

    bus_wr(A_EN, 32'h01);
    chk_irq(1'b0, "R7 enabled request drives irq_n low");
    bus_wr(A_ST, 32'hFE);
    bus_rd(A_ST, 32'h01, "R3 zero bits leave status");
    bus_wr(A_ST, 32'h01);
    bus_rd(A_ST, 32'h00, "R3 write one clears");
    chk_irq(1'b1, "R7 cleared request releases irq_n");

    @(negedge clk); src[0] = 1;
    @(negedge clk); src[0] = 0;
    @(negedge clk); src[0] = 1; sel = 1; wr = 1; addr = A_ST; wdata = 32'h01;
    @(negedge clk); src[0] = 0; sel = 0; wr = 0;
    bus_rd(A_ST, 32'h01, "R4 edge beats clear");
    bus_wr(A_ST, 32'h01);

    @(negedge clk); src[3] = 1;
    bus_rd(A_ST, 32'h08, "R2 bit3 edge");
    bus_wr(A_ST, 32'h08);
    bus_rd(A_ST, 32'h00, "R2 held source does not re-set");
    @(negedge clk); src[3] = 0;

    @(negedge clk); src[7] = 1;
    bus_rd(A_ST, 32'h80, "R5 receive ready live");
    bus_wr(A_ST, 32'h80);
    bus_rd(A_ST, 32'h80, "R5 write ignored on level bit");
    chk_irq(1'b1, "R8 level masked");
    bus_wr(A_EN, 32'hC0);
    chk_irq(1'b0, "R7 level enabled");
    @(negedge clk); src[7] = 0; src[6] = 1;
    bus_rd(A_ST, 32'h40, "R5 transmit ready live");
    @(negedge clk); src[6] = 0; #1;
    chk_irq(1'b1, "R7 level dropped");

    bus_wr(8'h20, 32'hFFFF_FFFF);
    bus_rd(A_EN, 32'hC0, "R9 unmapped write leaves enable");
    bus_rd(A_ST, 32'h00, "R9 unmapped write leaves status");
    bus_rd(8'h20, 32'h0, "R9 unmapped read zero");

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule